// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is an SPI target that sits in front of an on-chip byte array of 8192 locations. A host drives chip select, serial clock and serial data in, and receives serial data out with a separate output-enable for the pad. After chip select goes low, the first eight bits received form a command byte. Depending on that byte the engine sets or clears a write-enable latch, returns or updates a status byte, returns a fixed 32-bit identification word, enters a low-activity doze state, or takes a two-byte address and then streams memory bytes in either direction. The address advances by one after every byte and wraps from the top location to location zero as long as the host keeps clocking.

All SPI pins are brought into the system clock domain through synchronizers, and SPI clock edges are found by comparing successive synchronized samples. The system clock must therefore run at least four times faster than the SPI clock. Both SPI clock polarities that sample on the rising edge work: idle-low (mode 0) and idle-high (mode 3). Whether a write may actually land is not decided here. Every write attempt is raised on a request strobe, together with its target and the current status byte. An external protection unit answers in the same cycle with a grant.

Top module: `spi_mem_engine`

## Requirements
- R1: The command byte is taken MSB first from the bits sampled on the first eight rising SPI clock edges after chip select falls. This works with the clock idling low (mode 0) and idling high (mode 3).
- R2: Command 0x03, followed by a 16-bit address whose top three bits are ignored, returns array bytes MSB first. Output bits change on falling SPI clock edges. Each further 8 clocks return the byte at the next address.
- R3: Command 0x02, followed by a 16-bit address, writes each complete received byte to the current address and then advances the address. A byte cut short by chip select rising is dropped, and the location it aimed at keeps its old value.
- R4: During both read and write bursts, the address after 0x1FFF is 0x0000.
- R5: Each write attempt pulses `prot_req` for one cycle, with `prot_addr` set to the target and `prot_status_sel` high for a status write. The write takes effect only if `prot_grant` is high in that cycle.
- R6: Command 0x06 sets the write-enable latch, which is status bit 1. Command 0x04 clears it. A frame that ends before the eighth command bit leaves the latch unchanged.
- R7: Command 0x05 returns the status byte. Bits 7..2 are the stored bits, bit 1 is the write-enable latch and bit 0 reads 0. The byte repeats for as long as clocking continues.
- R8: Command 0x01 followed by one byte stores bits 7..2 of that byte when granted. Bits 1 and 0 of the byte have no effect.
- R9: Command 0x9F returns 0x04, 0x7F, 0x23, 0x03 in that order. After the 32nd bit, the data output keeps the last bit (1) until chip select rises.
- R10: `spi_sdo_oe` is high only in the data phase of commands 0x03, 0x05 and 0x9F. It is low within 3 system clocks after chip select rises.
- R11: A command byte that is not one of the eight listed (0x0B included) causes the rest of the frame to be ignored: no write request and no output enable.
- R12: If chip select rises after command 0xB9 with no rising SPI clock edge after the command byte, the engine dozes. The next frame is ignored completely, and the frame after it works normally. A rising SPI clock edge after 0xB9 cancels the doze.
- R13: After reset, `spi_sdo_oe` is low, the status byte is 0x00 and `prot_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SPI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the host |
| spi_sdi | input | 1 | Serial data from the host |
| spi_csn | input | 1 | Active-low chip select |
| spi_sdo | output | 1 | Serial data to the host |
| spi_sdo_oe | output | 1 | Drive enable for the serial data pad |
| prot_req | output | 1 | One-cycle strobe for each write attempt |
| prot_status_sel | output | 1 | High when the attempt targets the status byte |
| prot_addr | output | 13 | Array address of the attempted write |
| prot_status | output | 8 | Current status byte, for the permission decision |
| prot_grant | input | 1 | Permission for the attempt, valid in the request cycle |

## Verification
The embedded properties assume that chip select does not change in the same system cycle as an SPI clock edge, and that SPI clock half-periods are long enough for each edge to be seen as a separate event after synchronization. They also assume that the grant is settled when a request strobe is raised. The stimulus keeps the SPI clock half-period at eight system clocks and changes data and chip select only while the clock is steady. It changes inputs on the falling system clock edge. Its grant is a level that is set between frames. Each frame is opened and closed with the clock at its idle level for the chosen mode.

// File: rtl/spi_mem_pkg.sv
// Shared constants and types for the SPI serial memory command engine.
// Assumes 8-bit command/data units and a 32-bit identification word.
package spi_mem_pkg;
    localparam int BYTE_W = 8;
    localparam int ID_W   = 32;
    localparam logic [ID_W-1:0] ID_WORD = 32'h047F_2303;

    localparam logic [BYTE_W-1:0] OP_WEN_SET = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WEN_CLR = 8'h04;
    localparam logic [BYTE_W-1:0] OP_STAT_RD = 8'h05;
    localparam logic [BYTE_W-1:0] OP_STAT_WR = 8'h01;
    localparam logic [BYTE_W-1:0] OP_MEM_RD  = 8'h03;
    localparam logic [BYTE_W-1:0] OP_MEM_WR  = 8'h02;
    localparam logic [BYTE_W-1:0] OP_ID_RD   = 8'h9F;
    localparam logic [BYTE_W-1:0] OP_DOZE    = 8'hB9;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_MEM_RD,
        ST_MEM_WR,
        ST_STAT_RD,
        ST_STAT_WR,
        ST_ID_RD,
        ST_DISCARD,
        ST_DOZE_ARM,
        ST_DOZE
    } eng_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Multi-stage synchronizer for a group of asynchronous pins.
// Assumes each pin is stable for longer than STAGES+1 system clocks
// between changes; STAGES must be at least 2.
module spi_pin_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_lvl
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift pin samples through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], pin_in};
    end

    assign pin_lvl = chain[STAGES-1];
endmodule

// File: rtl/spi_mem_array.sv
// Inferred byte-wide storage array with one write port and an
// asynchronous read port. It holds no reset, as befits a memory.
module spi_mem_array #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Commit one byte per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/spi_cmd_ctrl.sv
// Command controller: finds SPI clock and select edges, decodes the
// command byte, gathers the address, and moves data in and out.
// Assumes synchronized pin levels and a system clock at least 4x the SPI
// clock, with chip select never changing in the same cycle as an SPI edge.
module spi_cmd_ctrl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int FRAME_ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_lvl,
    input  logic              sdi_lvl,
    input  logic              csn_lvl,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              prot_grant,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              prot_req,
    output logic              prot_status_sel,
    output logic [BYTE_W-1:0] status_byte
);
    localparam int CNT_W     = $clog2(FRAME_ADDR_W) + 1;
    localparam int OCNT_W    = $clog2(ID_W) + 1;
    localparam int BIT_IDX_W = $clog2(BYTE_W);
    localparam int STAT_KEEP = BYTE_W - 2;

    eng_state_t              state;
    logic                    sck_d, csn_d;
    logic [CNT_W-1:0]        bit_cnt;
    logic [OCNT_W-1:0]       out_cnt;
    logic [FRAME_ADDR_W-1:0] in_sh;
    logic [ADDR_W-1:0]       addr;
    logic [ID_W-1:0]         out_sh;
    logic                    sdo_q, oe_q, wel_q, is_wr_q;
    logic [STAT_KEEP-1:0]    stat_q;

    logic                    sck_rise, sck_fall, cs_fall, byte_done, addr_done;
    logic [FRAME_ADDR_W-1:0] in_next;
    logic [BYTE_W-1:0]       in_byte, load_byte;

    // Edge events and the bit that completes the current shift.
    always_comb begin
        sck_rise  = sck_lvl & ~sck_d;
        sck_fall  = ~sck_lvl & sck_d;
        cs_fall   = ~csn_lvl & csn_d;
        in_next   = {in_sh[FRAME_ADDR_W-2:0], sdi_lvl};
        in_byte   = in_next[BYTE_W-1:0];
        byte_done = (bit_cnt == CNT_W'(BYTE_W - 1));
        addr_done = (bit_cnt == CNT_W'(FRAME_ADDR_W - 1));
        load_byte = (state == ST_MEM_RD) ? rd_data : status_byte;
    end

    // Write-attempt strobe toward the protection unit and the array port.
    always_comb begin
        prot_req        = !csn_lvl && sck_rise && byte_done &&
                          (state == ST_MEM_WR || state == ST_STAT_WR);
        prot_status_sel = (state == ST_STAT_WR);
        mem_we          = prot_req && prot_grant && (state == ST_MEM_WR);
        mem_wdata       = in_byte;
        mem_addr        = addr;
        status_byte     = {stat_q, wel_q, 1'b0};
        sdo             = sdo_q;
        sdo_oe          = oe_q;
    end

    // Frame sequencing, decoding, input shifting and output shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sck_d   <= 1'b0;
            csn_d   <= 1'b1;
            bit_cnt <= '0;
            out_cnt <= '0;
            in_sh   <= '0;
            addr    <= '0;
            out_sh  <= '0;
            sdo_q   <= 1'b0;
            oe_q    <= 1'b0;
            wel_q   <= 1'b0;
            is_wr_q <= 1'b0;
            stat_q  <= '0;
        end else begin
            sck_d <= sck_lvl;
            csn_d <= csn_lvl;
            if (csn_lvl) begin
                state   <= (state == ST_DOZE_ARM || state == ST_DOZE) ? ST_DOZE : ST_IDLE;
                oe_q    <= 1'b0;
                bit_cnt <= '0;
                out_cnt <= '0;
            end else if (cs_fall) begin
                state   <= (state == ST_DOZE) ? ST_DISCARD : ST_OPCODE;
                bit_cnt <= '0;
                out_cnt <= '0;
                in_sh   <= '0;
            end else if (sck_rise) begin
                in_sh   <= in_next;
                bit_cnt <= bit_cnt + 1'b1;
                case (state)
                    ST_OPCODE: begin
                        if (byte_done) begin
                            bit_cnt <= '0;
                            case (in_byte)
                                OP_WEN_SET: begin wel_q <= 1'b1; state <= ST_DISCARD; end
                                OP_WEN_CLR: begin wel_q <= 1'b0; state <= ST_DISCARD; end
                                OP_STAT_RD: state <= ST_STAT_RD;
                                OP_STAT_WR: state <= ST_STAT_WR;
                                OP_MEM_RD:  begin is_wr_q <= 1'b0; state <= ST_ADDR; end
                                OP_MEM_WR:  begin is_wr_q <= 1'b1; state <= ST_ADDR; end
                                OP_ID_RD:   begin out_sh <= ID_WORD; state <= ST_ID_RD; end
                                OP_DOZE:    state <= ST_DOZE_ARM;
                                default:    state <= ST_DISCARD;
                            endcase
                        end
                    end
                    ST_ADDR: begin
                        if (addr_done) begin
                            addr    <= in_next[ADDR_W-1:0];
                            bit_cnt <= '0;
                            state   <= is_wr_q ? ST_MEM_WR : ST_MEM_RD;
                        end
                    end
                    ST_MEM_WR: begin
                        if (byte_done) begin
                            bit_cnt <= '0;
                            addr    <= addr + 1'b1;
                        end
                    end
                    ST_STAT_WR: begin
                        if (byte_done) begin
                            if (prot_grant) stat_q <= in_byte[BYTE_W-1:2];
                            state <= ST_DISCARD;
                        end
                    end
                    ST_DOZE_ARM: state <= ST_DISCARD;
                    default: ;
                endcase
            end else if (sck_fall) begin
                case (state)
                    ST_MEM_RD, ST_STAT_RD: begin
                        oe_q    <= 1'b1;
                        out_cnt <= out_cnt + 1'b1;
                        if (out_cnt[BIT_IDX_W-1:0] == '0) begin
                            sdo_q  <= load_byte[BYTE_W-1];
                            out_sh <= {load_byte[BYTE_W-2:0], {(ID_W-BYTE_W+1){1'b0}}};
                            if (state == ST_MEM_RD) addr <= addr + 1'b1;
                        end else begin
                            sdo_q  <= out_sh[ID_W-1];
                            out_sh <= out_sh << 1;
                        end
                    end
                    ST_ID_RD: begin
                        oe_q <= 1'b1;
                        if (out_cnt != OCNT_W'(ID_W)) begin
                            sdo_q   <= out_sh[ID_W-1];
                            out_sh  <= out_sh << 1;
                            out_cnt <= out_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output must be released one cycle after select is seen high.
    assert_sdo_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        csn_lvl |=> !sdo_oe);

    // Drive enable may only be seen in a data-returning command.
    assert_oe_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (state == ST_MEM_RD || state == ST_STAT_RD || state == ST_ID_RD));

    // The write-enable latch only moves on a decoded command byte.
    assert_wel_decode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_q != $past(wel_q)) |-> ($past(state) == ST_OPCODE));

    // Within a burst the address only steps by one, modulo the array size.
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_MEM_WR || state == ST_MEM_RD) && ($past(state) == state) &&
         (addr != $past(addr))) |-> (addr == ADDR_W'($past(addr) + 1'b1)));

    // The identification counter saturates at the word length.
    assert_id_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ID_RD) |-> (out_cnt <= OCNT_W'(ID_W)));

    // A dozing engine never drives the output.
    assert_doze_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOZE) |-> !sdo_oe);
endmodule

// File: rtl/spi_mem_engine.sv
// Top level of the SPI serial memory command engine: pin synchronizers,
// command controller and storage array. Assumes clk is at least 4x the
// SPI clock and that prot_grant is settled whenever prot_req is high.
module spi_mem_engine
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int FRAME_ADDR_W = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_sdi,
    input  logic              spi_csn,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic              prot_req,
    output logic              prot_status_sel,
    output logic [ADDR_W-1:0] prot_addr,
    output logic [BYTE_W-1:0] prot_status,
    input  logic              prot_grant
);
    localparam int PIN_N = 3;

    logic [PIN_N-1:0]  pin_lvl;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [BYTE_W-1:0] mem_wdata, mem_rdata;

    spi_pin_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  ({spi_csn, spi_sdi, spi_sck}),
        .pin_lvl (pin_lvl)
    );

    spi_cmd_ctrl #(
        .ADDR_W       (ADDR_W),
        .FRAME_ADDR_W (FRAME_ADDR_W)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .sck_lvl         (pin_lvl[0]),
        .sdi_lvl         (pin_lvl[1]),
        .csn_lvl         (pin_lvl[2]),
        .rd_data         (mem_rdata),
        .prot_grant      (prot_grant),
        .mem_we          (mem_we),
        .mem_addr        (mem_addr),
        .mem_wdata       (mem_wdata),
        .sdo             (spi_sdo),
        .sdo_oe          (spi_sdo_oe),
        .prot_req        (prot_req),
        .prot_status_sel (prot_status_sel),
        .status_byte     (prot_status)
    );

    spi_mem_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (BYTE_W)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign prot_addr = mem_addr;
endmodule

// File: tb/spi_mem_engine_test.sv
`timescale 1ns/1ps
module spi_mem_engine_test;
    localparam int HALF = 8;
    localparam logic [23:0] VEC [8] = '{
        24'h0010A5, 24'hE0115A, 24'h010111, 24'h0ABCFF,
        24'h123400, 24'hFF00C3, 24'h077781, 24'h10007E
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, csn = 1'b1, allow = 1'b1;
    logic sdo, sdo_oe, preq, psel;
    logic [12:0] paddr;
    logic [7:0]  pstat;
    int tests = 0, fails = 0, oe_cnt = 0, req_cnt = 0;
    logic [12:0] req_addr = '0;
    logic cur_m3 = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    spi_mem_engine uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_sdi(sdi), .spi_csn(csn),
        .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .prot_req(preq), .prot_status_sel(psel),
        .prot_addr(paddr), .prot_status(pstat), .prot_grant(allow)
    );

    // Observe outputs away from the active edge.
    always @(negedge clk) begin
        if (sdo_oe) oe_cnt = oe_cnt + 1;
        if (preq) begin req_cnt = req_cnt + 1; req_addr = paddr; end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic frame_open(input logic m3);
        cur_m3 = m3;
        sck = m3;
        tick(4);
        csn = 1'b0;
        tick(HALF);
    endtask

    task automatic frame_close();
        tick(HALF);
        if (!cur_m3) begin sck = 1'b0; tick(HALF); end
        csn = 1'b1;
        tick(2*HALF);
    endtask

    task automatic clock_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            sck = 1'b0; sdi = tx[i];
            tick(HALF);
            rx[i] = sdo;
            sck = 1'b1;
            tick(HALF);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        clock_bits(tx, 8, rx);
    endtask

    task automatic cmd_only(input logic m3, input logic [7:0] op);
        logic [7:0] d;
        frame_open(m3); xfer(op, d); frame_close();
    endtask

    task automatic mem_wr1(input logic m3, input logic [15:0] a, input logic [7:0] v);
        logic [7:0] d;
        frame_open(m3);
        xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d); xfer(v, d);
        frame_close();
    endtask

    task automatic mem_rd1(input logic m3, input logic [15:0] a, output logic [7:0] v);
        logic [7:0] d;
        frame_open(m3);
        xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d); xfer(8'h00, v);
        frame_close();
    endtask

    task automatic stat_rd(input logic m3, output logic [7:0] v);
        logic [7:0] d;
        frame_open(m3); xfer(8'h05, d); xfer(8'h00, v); frame_close();
    endtask

    task automatic stat_wr(input logic m3, input logic [7:0] v);
        logic [7:0] d;
        frame_open(m3); xfer(8'h01, d); xfer(v, d); frame_close();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, d2, d3;
        int oe0, rq0;
        tick(6);
        rst_n = 1'b1;
        tick(2);
        // R13: reset state
        chk("R13 oe after reset", {31'd0, sdo_oe}, 32'd0);
        chk("R13 status after reset", {24'd0, pstat}, 32'h00);
        chk("R13 req after reset", {31'd0, preq}, 32'd0);

        // R7: status read in mode 0
        stat_rd(1'b0, d);
        chk("R7 status initial", {24'd0, d}, 32'h00);
        // R1 R6: set latch in mode 3
        cmd_only(1'b1, 8'h06);
        stat_rd(1'b1, d);
        chk("R1 R6 latch set mode3", {24'd0, d}, 32'h02);

        // R2 R3: table walk, write then read through aliased addresses
        for (int i = 0; i < 8; i++) mem_wr1(i[0], VEC[i][23:8], VEC[i][7:0]);
        for (int i = 0; i < 8; i++) begin
            mem_rd1(!i[0], VEC[i][23:8] ^ 16'hE000, d);
            chk($sformatf("R2 R3 table entry %0d", i), {24'd0, d}, {24'd0, VEC[i][7:0]});
        end

        // R4: write burst across the top of the array, top address bits set
        frame_open(1'b1);
        xfer(8'h02, d); xfer(8'hFF, d); xfer(8'hFE, d);
        xfer(8'hA1, d); xfer(8'hB2, d); xfer(8'hC3, d);
        frame_close();
        frame_open(1'b0);
        xfer(8'h03, d); xfer(8'h1F, d); xfer(8'hFE, d);
        xfer(8'h00, d); xfer(8'h00, d2); xfer(8'h00, d3);
        frame_close();
        chk("R2 burst byte 0", {24'd0, d}, 32'hA1);
        chk("R4 burst byte at top", {24'd0, d2}, 32'hB2);
        chk("R4 read wrap to zero", {24'd0, d3}, 32'hC3);
        mem_rd1(1'b1, 16'h0000, d);
        chk("R4 write wrap to zero", {24'd0, d}, 32'hC3);

        // R3: partial byte at select rise is dropped
        frame_open(1'b0);
        xfer(8'h02, d); xfer(8'h01, d); xfer(8'h00, d);
        xfer(8'h5A, d); clock_bits(8'hF0, 4, d);
        frame_close();
        mem_rd1(1'b0, 16'h0100, d);
        chk("R3 full byte written", {24'd0, d}, 32'h5A);
        mem_rd1(1'b0, 16'h0101, d);
        chk("R3 partial byte dropped", {24'd0, d}, 32'h11);

        // R5: request without grant
        allow = 1'b0;
        rq0 = req_cnt;
        mem_wr1(1'b0, 16'h0100, 8'hFF);
        chk("R5 one request", req_cnt - rq0, 32'd1);
        chk("R5 request address", {19'd0, req_addr}, 32'h0100);
        mem_rd1(1'b0, 16'h0100, d);
        chk("R5 denied write", {24'd0, d}, 32'h5A);
        allow = 1'b1;

        // R8 R6: status write and latch clear
        stat_wr(1'b0, 8'hFF);
        stat_rd(1'b0, d);
        chk("R8 status all ones", {24'd0, d}, 32'hFE);
        cmd_only(1'b0, 8'h04);
        stat_rd(1'b1, d);
        chk("R6 latch cleared", {24'd0, d}, 32'hFC);
        allow = 1'b0;
        stat_wr(1'b1, 8'h00);
        stat_rd(1'b1, d);
        chk("R8 R5 denied status write", {24'd0, d}, 32'hFC);
        allow = 1'b1;
        stat_wr(1'b1, 8'h03);
        stat_rd(1'b0, d);
        chk("R8 low bits ignored", {24'd0, d}, 32'h00);

        // R7: repeated status byte
        stat_wr(1'b0, 8'hA4);
        frame_open(1'b0);
        xfer(8'h05, d); xfer(8'h00, d); xfer(8'h00, d2);
        frame_close();
        chk("R7 repeat first", {24'd0, d}, 32'hA4);
        chk("R7 repeat second", {24'd0, d2}, 32'hA4);

        // R9: identification word and held last bit
        frame_open(1'b1);
        xfer(8'h9F, d);
        xfer(8'h00, d); chk("R9 id byte 0", {24'd0, d}, 32'h04);
        xfer(8'h00, d); chk("R9 id byte 1", {24'd0, d}, 32'h7F);
        xfer(8'h00, d); chk("R9 id byte 2", {24'd0, d}, 32'h23);
        xfer(8'h00, d); chk("R9 id byte 3", {24'd0, d}, 32'h03);
        xfer(8'h00, d); chk("R9 last bit held", {24'd0, d}, 32'hFF);
        tick(HALF);
        csn = 1'b1;
        tick(4);
        chk("R10 release after select rise", {31'd0, sdo_oe}, 32'd0);
        tick(2*HALF);

        // R6 R1: command cut short leaves latch alone
        frame_open(1'b0);
        clock_bits(8'h06, 7, d);
        frame_close();
        stat_rd(1'b0, d);
        chk("R6 aborted command", {24'd0, d}, 32'hA4);

        // R10: no drive during a command without data return
        oe0 = oe_cnt;
        cmd_only(1'b1, 8'h06);
        chk("R10 no drive on latch command", oe_cnt - oe0, 32'd0);
        cmd_only(1'b1, 8'h04);

        // R11: unknown command ignores the rest of the frame
        oe0 = oe_cnt; rq0 = req_cnt;
        frame_open(1'b0);
        xfer(8'h0B, d); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h10, d); xfer(8'h99, d);
        frame_close();
        chk("R11 no drive", oe_cnt - oe0, 32'd0);
        chk("R11 no request", req_cnt - rq0, 32'd0);
        mem_rd1(1'b0, 16'h0010, d);
        chk("R11 memory untouched", {24'd0, d}, 32'hA5);

        // R12: doze, ignored frame, then normal frame
        cmd_only(1'b0, 8'hB9);
        oe0 = oe_cnt;
        stat_rd(1'b0, d);
        chk("R12 frame ignored while dozing", oe_cnt - oe0, 32'd0);
        stat_rd(1'b0, d);
        chk("R12 normal after wake", {24'd0, d}, 32'hA4);
        // R12: extra clock cancels doze
        frame_open(1'b1);
        xfer(8'hB9, d); clock_bits(8'h00, 1, d);
        frame_close();
        stat_rd(1'b1, d);
        chk("R12 doze cancelled", {24'd0, d}, 32'hA4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule